// File: doc/BRIEF.md
# Peripheral Interrupt Flag/Enable Unit

This unit is the interrupt status and mask stage of a small parallel I/O and timer peripheral. Seven event sources each raise a flag: two timer events, handshake-line edges and a shift event. The sources are the timer, port and edge-detection logic that sit next to the unit, and each delivers a one-cycle pulse. A flag latches on its pulse whether or not it is enabled, so software can poll it. Only flags whose enable bit is also set reach the active-low interrupt request.

Software uses a simple register interface: `sel` marks an access, `we` selects a write, and `rdata` returns the selected register in the same cycle. Reading the flag register returns the seven flags below a summary bit 7, which is computed and not stored. Writing the flag register clears the bits written as one. The enable register is written with set/clear semantics, chosen by bit 7 of the written byte. Some accesses to neighbouring registers clear flags as a side effect: the timer low counter reads and any port A data access.

Top module: `irq_flag_unit`

## Requirements
- R1: A flag bit becomes 1 on the clock edge after its event pulse, regardless of its enable bit. Flag bit i is `evt[i]`. Bit 6 is the first timer, bit 5 the second timer, and bits 1 and 0 are the two port A handshake lines.
- R2: Reading the flag register (address 13) returns `{summary, flags[6:0]}`. The summary bit 7 is 1 exactly when some flag bit and its enable bit are both 1.
- R3: `irq_n` is 0 exactly when the summary bit is 1. Flags that are pending but not enabled never pull it low.
- R4: When an enable bit is cleared while its flag is pending, that flag stops driving `irq_n` on the very next edge, and the flag itself stays set.
- R5: A write to the flag register clears each of bits 6..0 written as one and leaves the rest unchanged. Bit 7 of the write data has no effect.
- R6: A read of address 4 (first timer, low count) clears flag bit 6. A read of address 8 (second timer, low count) clears flag bit 5. Writes to those addresses clear nothing.
- R7: A read or a write of address 1 (port A data) clears flag bits 1 and 0.
- R8: A write to the enable register (address 14) with data bit 7 = 1 sets the enable bits written as one. With bit 7 = 0 it clears them. The other enable bits keep their values; for example, 0x20 disables only the second timer. A read of address 14 returns `{1, enables[6:0]}`.
- R9: When an event pulse and a clearing access hit the same flag in the same cycle, the flag ends up set.
- R10: After reset all flags and enables are 0 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 7 | One-cycle event pulses, bit i sets flag i |
| sel | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register, combinational |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is a collision: an event pulse arrives in the same cycle as an access that clears the same flag, or an enable is dropped while its flag is still pending. The bench reaches these states by putting the event pulse and the bus access into one shared drive cycle. It then reads the flag register back and watches `irq_n` right after the edge. A sweep over all 128 enable patterns, each paired with several event patterns, covers the summary bit and the request output in every mask combination.

// File: rtl/irq_flag_unit.sv
module irq_flag_unit #(
  parameter int AW     = 4,
  parameter int A_PA   = 1,
  parameter int A_T1LO = 4,
  parameter int A_T2LO = 8,
  parameter int A_FLAG = 13,
  parameter int A_EN   = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    evt,
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq_n
);
  localparam logic [AW-1:0] PA_AD = AW'(A_PA);
  localparam logic [AW-1:0] T1_AD = AW'(A_T1LO);
  localparam logic [AW-1:0] T2_AD = AW'(A_T2LO);
  localparam logic [AW-1:0] FL_AD = AW'(A_FLAG);
  localparam logic [AW-1:0] EN_AD = AW'(A_EN);

  logic [6:0] flags, en, clr;
  logic       rd, wr, pend;

  assign rd   = sel & ~we;
  assign wr   = sel & we;
  assign pend = |(flags & en);
  assign irq_n = ~pend;

  always_comb begin
    clr = '0;
    if (wr && addr == FL_AD) clr = wdata[6:0];
    if (rd && addr == T1_AD) clr[6] = 1'b1;
    if (rd && addr == T2_AD) clr[5] = 1'b1;
    if (sel && addr == PA_AD) clr[1:0] = 2'b11;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) en <= '0;
    else if (wr && addr == EN_AD)
      en <= wdata[7] ? (en | wdata[6:0]) : (en & ~wdata[6:0]);

  always_comb begin
    rdata = 8'h00;
    if (addr == FL_AD)      rdata = {pend, flags};
    else if (addr == EN_AD) rdata = {1'b1, en};
  end
endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk #(
  parameter int AW     = 4,
  parameter int A_PA   = 1,
  parameter int A_T1LO = 4,
  parameter int A_T2LO = 8,
  parameter int A_FLAG = 13,
  parameter int A_EN   = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic [6:0]    evt,
  input logic          sel,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          irq_n,
  input logic [6:0]    flags,
  input logic [6:0]    en
);
  p_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(evt)) == $past(evt)));

  p_summary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(A_FLAG)) |-> (rdata[7] == !irq_n));

  p_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == 7'd0) |-> irq_n);

  p_keep_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we && addr == AW'(A_EN)) |=> ((flags & $past(flags)) == $past(flags)));

  p_flag_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we && addr == AW'(A_FLAG)) |=> ((flags & $past(wdata[6:0] & ~evt)) == 7'd0));

  p_t1_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we && addr == AW'(A_T1LO) && !evt[6]) |=> !flags[6]);

  p_pa_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && addr == AW'(A_PA) && evt[1:0] == 2'b00) |=> (flags[1:0] == 2'b00));

  p_en_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we && addr == AW'(A_EN) && wdata[7]) |=> ((en & $past(wdata[6:0])) == $past(wdata[6:0])));

  p_en_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == AW'(A_EN)) |-> rdata[7]);
endmodule

bind irq_flag_unit irq_flag_unit_chk #(
  .AW(AW), .A_PA(A_PA), .A_T1LO(A_T1LO), .A_T2LO(A_T2LO), .A_FLAG(A_FLAG), .A_EN(A_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .sel(sel), .we(we), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq_n(irq_n), .flags(flags), .en(en)
);

// File: tb/sim_irq_flag_unit.sv
module sim_irq_flag_unit;
  localparam int CLK = 10;
  localparam logic [3:0] PA = 4'd1, T1 = 4'd4, T2 = 4'd8, FL = 4'd13, EN = 4'd14;

  logic clk = 0, rst_n = 0, sel = 0, we = 0;
  logic [6:0] evt = '0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq_n;
  int errs = 0, checks = 0;
  logic [6:0] mf, me;
  bit done = 0;

  irq_flag_unit u0 (.clk(clk), .rst_n(rst_n), .evt(evt), .sel(sel), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n));

  always #(CLK/2) clk = ~clk;

  task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] flag_byte();
    return {|(mf & me), mf};
  endfunction

  task automatic cyc(input logic s, input logic w, input logic [3:0] a,
                     input logic [7:0] d, input logic [6:0] e);
    logic [6:0] c;
    @(negedge clk);
    sel = s; we = w; addr = a; wdata = d; evt = e;
    c = '0;
    if (s && w && a == FL) c = d[6:0];
    if (s && !w && a == T1) c[6] = 1;
    if (s && !w && a == T2) c[5] = 1;
    if (s && a == PA) c[1:0] = 2'b11;
    @(posedge clk);
    mf = (mf & ~c) | e;
    if (s && w && a == EN) me = d[7] ? (me | d[6:0]) : (me & ~d[6:0]);
    #1 sel = 0; we = 0; evt = '0; addr = '0;
  endtask

  task automatic rd_chk(input string r, input logic [3:0] a);
    @(negedge clk);
    addr = a; #1;
    chk(r, rdata, a == FL ? flag_byte() : {1'b1, me});
  endtask

  task automatic irq_chk(input string r);
    chk(r, {7'd0, irq_n}, {7'd0, ~|(mf & me)});
  endtask

  initial begin
    #(CLK * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    mf = '0; me = '0;
    #(CLK*3) rst_n = 1;
    // R10 reset state
    rd_chk("R10 flags", FL);
    rd_chk("R10 enables", EN);
    irq_chk("R10 irq");

    // R1 R2 R3 R8 sweep of every enable mask
    for (int e = 0; e < 128; e++) begin
      cyc(1, 1, EN, 8'h7F, '0);
      cyc(1, 1, EN, 8'h80 | 8'(e), '0);
      rd_chk("R8 enable set", EN);
      for (int k = 0; k < 3; k++) begin
        logic [6:0] f;
        f = 7'((e * 37 + k * 53 + 11) & 127);
        cyc(0, 0, 4'd0, 8'h00, f);
        rd_chk("R1 R2 flag latch/summary", FL);
        irq_chk("R3 irq");
        cyc(1, 1, FL, 8'h7F, '0);
        rd_chk("R5 flags cleared", FL);
      end
    end

    // R8 clear with bit7 low: 0x20 drops only timer2 enable
    cyc(1, 1, EN, 8'hFF, '0);
    cyc(1, 1, EN, 8'h20, '0);
    rd_chk("R8 clear 0x20", EN);
    chk("R8 value", {1'b1, me}, 8'hDF);

    // R4 drop enables one by one with all flags pending
    cyc(1, 1, EN, 8'hFF, 7'h7F);
    for (int i = 0; i < 7; i++) begin
      cyc(1, 1, EN, 8'(1 << i), '0);
      irq_chk("R4 irq follows enable");
      rd_chk("R4 flag kept", FL);
    end
    chk("R4 flags intact", {1'b0, mf}, 8'h7F);

    // R5 bit7 write has no effect, then single-bit clears
    cyc(1, 1, EN, 8'h81, '0);
    cyc(1, 1, FL, 8'h80, '0);
    rd_chk("R5 bit7 ignored", FL);
    for (int i = 0; i < 7; i++) begin
      cyc(1, 1, FL, 8'(1 << i), '0);
      rd_chk("R5 single clear", FL);
      irq_chk("R5 irq");
    end

    // R6 timer side-effect clears
    cyc(0, 0, 4'd0, 8'h00, 7'h7F);
    cyc(1, 1, T1, 8'hFF, '0);
    rd_chk("R6 write T1 no clear", FL);
    cyc(1, 0, T1, 8'h00, '0);
    rd_chk("R6 read T1 clears bit6", FL);
    cyc(1, 0, T2, 8'h00, '0);
    rd_chk("R6 read T2 clears bit5", FL);
    chk("R6 value", {1'b0, mf}, 8'h1F);

    // R7 port A read and write
    cyc(1, 0, PA, 8'h00, '0);
    rd_chk("R7 read PA", FL);
    cyc(0, 0, 4'd0, 8'h00, 7'h03);
    cyc(1, 1, PA, 8'h55, '0);
    rd_chk("R7 write PA", FL);
    chk("R7 value", {1'b0, mf}, 8'h1C);

    // R9 set wins over clear
    cyc(1, 0, T1, 8'h00, 7'h40);
    rd_chk("R9 T1 read vs event", FL);
    cyc(1, 1, FL, 8'h08, 7'h08);
    rd_chk("R9 flag write vs event", FL);
    cyc(1, 1, PA, 8'h00, 7'h01);
    rd_chk("R9 PA vs event", FL);
    chk("R9 value", {1'b0, mf}, 8'h5D);

    // R10 reset mid-run
    rst_n = 0; mf = '0; me = '0;
    #(CLK*2) rst_n = 1;
    rd_chk("R10 flags after reset", FL);
    irq_chk("R10 irq after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule